// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps a small programmable mode setting for a burst-oriented memory controller and turns each access command into the ordered list of column addresses for that burst. A mode-load strobe, qualified by a two-bit bank selector, copies a nine-bit mode word into the block. The mode word sets the burst length (2, 4 or 8), the burst ordering (sequential or interleaved), a latency code and an operating-mode field. Codes outside the legal set raise an invalid flag. A load that asks for a DLL reset also produces a one-cycle pulse.

A start strobe with a column address begins a burst. From the next clock on, the block presents one column address per cycle while `busy` is high, and raises `last` on the final beat. The upper column bits pick an aligned block, and they stay fixed for the whole burst. The low bits begin at the start offset and wrap inside that block. In sequential order they count up. In interleaved order they are the start offset XOR the beat index. Read and write bursts use the same sequence. Length and ordering are latched at start, so a mode load during a burst does not change the burst already running.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `busy`, `last`, `dll_rst_pulse` and `mode_invalid` are 0, and the mode is burst length 2, sequential order, latency code 010, operating field 00.
- R2: Mode word bits [2:0] set the burst length: 001 gives 2, 010 gives 4, 011 gives 8. Any other value sets `mode_invalid`.
- R3: Mode word bit [3] sets the ordering. With 0, beat i carries low offset (start + i) mod length. With 1, beat i carries start XOR i.
- R4: Mode word bits [6:4] are the latency code. Only 010 and 110 are legal; any other code sets `mode_invalid`.
- R5: Mode word bits [8:7] are the operating field. 00 and 10 are legal and 01 and 11 set `mode_invalid`. An accepted load with 10 drives `dll_rst_pulse` high for exactly the one cycle after the load edge.
- R6: A load with `mode_bank` other than 00 leaves the mode setting unchanged.
- R7: Column bits above the low log2(length) bits equal those of `start_col` on every beat of the burst.
- R8: An accepted start makes `busy` high for exactly length cycles, starting at the next edge. `last` is high on the final beat only.
- R9: A start while `busy` is high is ignored, and the running sequence is not disturbed.
- R10: A start while `mode_invalid` is high is refused, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode-load strobe |
| mode_bank | input | 2 | Bank selector; must be 00 for a load to apply |
| mode_word | input | 9 | Mode word: length [2:0], order [3], latency [6:4], operating field [8:7] |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Starting column address |
| busy | output | 1 | Burst in progress; `col_out` valid |
| col_out | output | COL_W | Column address of the current beat |
| last | output | 1 | Final beat of the burst |
| mode_invalid | output | 1 | Stored mode holds a reserved code |
| dll_rst_pulse | output | 1 | One-cycle DLL-reset request |

## Verification
The bench starts bursts at offsets that wrap, such as 2 in length 4 and 5 in length 8 interleaved. A design that added carry into the upper bits, or counted instead of XORing, would produce a column outside the aligned block or in the wrong order. It loads reserved codes into each field one at a time and expects the invalid flag, then sends a start that must be refused. A design that checked only the length field would begin a burst. It sends a load with a non-zero bank select carrying an illegal word, and a start in the middle of a burst. A design that did not qualify the load would flag invalid, and one that restarted would repeat or lengthen the sequence. It also checks that the DLL pulse lasts one cycle only and appears only for operating field 10.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [1:0]       mode_bank,
  input  logic [8:0]       mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  output logic             busy,
  output logic [COL_W-1:0] col_out,
  output logic             last,
  output logic             mode_invalid,
  output logic             dll_rst_pulse
);
  localparam logic [8:0] MODE_RST = 9'h021;
  localparam int         OFF_W    = 3;

  logic [8:0]       mode_q;
  logic             busy_q, dll_q, ilv_q;
  logic [OFF_W-1:0] mask_q, beat_q, cur_mask, off;
  logic [COL_W-1:0] base_q, wide_mask;
  logic             len_ok, lat_ok, op_ok, load_ok, go;

  assign load_ok = mode_load && (mode_bank == 2'b00);
  assign len_ok  = (mode_q[2:0] != 3'd0) && (mode_q[2:0] <= 3'd3);
  assign lat_ok  = (mode_q[6:4] == 3'b010) || (mode_q[6:4] == 3'b110);
  assign op_ok   = (mode_q[8:7] == 2'b00) || (mode_q[8:7] == 2'b10);
  assign mode_invalid = !(len_ok && lat_ok && op_ok);
  assign go = start && !busy_q && !mode_invalid;

  always_comb begin
    case (mode_q[1:0])
      2'd1:    cur_mask = 3'b001;
      2'd2:    cur_mask = 3'b011;
      default: cur_mask = 3'b111;
    endcase
  end

  assign off       = ilv_q ? (base_q[OFF_W-1:0] ^ beat_q) : (base_q[OFF_W-1:0] + beat_q);
  assign wide_mask = {{(COL_W-OFF_W){1'b0}}, mask_q};
  assign col_out   = (base_q & ~wide_mask) | ({{(COL_W-OFF_W){1'b0}}, off} & wide_mask);
  assign last      = busy_q && (beat_q == mask_q);
  assign busy      = busy_q;
  assign dll_rst_pulse = dll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      dll_q  <= 1'b0;
    end else begin
      dll_q <= load_ok && (mode_word[8:7] == 2'b10);
      if (load_ok) mode_q <= mode_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      mask_q <= 3'b001;
      ilv_q  <= 1'b0;
      base_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      mask_q <= cur_mask;
      ilv_q  <= mode_q[3];
      base_q <= start_col;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + 3'd1;
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_load,
  input logic [1:0]       mode_bank,
  input logic [8:0]       mode_word,
  input logic             start,
  input logic             busy,
  input logic [COL_W-1:0] col_out,
  input logic             last,
  input logic             mode_invalid,
  input logic             dll_rst_pulse
);
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(last) |-> col_out[COL_W-1:3] == $past(col_out[COL_W-1:3]));

  p_last_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !mode_invalid |=> busy);

  p_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode_invalid |=> !busy);

  p_dll_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst_pulse |-> $past(mode_load && mode_bank == 2'b00 && mode_word[8:7] == 2'b10));

  p_bank_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load && mode_bank != 2'b00 |=> $stable(mode_invalid) && !dll_rst_pulse);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bank(mode_bank),
  .mode_word(mode_word), .start(start), .busy(busy), .col_out(col_out),
  .last(last), .mode_invalid(mode_invalid), .dll_rst_pulse(dll_rst_pulse)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_load = 1'b0;
  logic [1:0]       mode_bank = 2'b00;
  logic [8:0]       mode_word = '0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             busy, last, mode_invalid, dll_rst_pulse;
  logic [COL_W-1:0] col_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_bank(mode_bank),
    .mode_word(mode_word), .start(start), .start_col(start_col), .busy(busy),
    .col_out(col_out), .last(last), .mode_invalid(mode_invalid),
    .dll_rst_pulse(dll_rst_pulse)
  );

  function automatic logic [8:0] mw(input logic [1:0] op, input logic [2:0] lat,
                                    input logic ilv, input logic [2:0] len);
    return {op, lat, ilv, len};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] bank, input logic [8:0] w, input string req,
                      input int exp_inv, input int exp_dll);
    @(negedge clk);
    mode_load = 1'b1; mode_bank = bank; mode_word = w;
    @(negedge clk);
    mode_load = 1'b0; mode_bank = 2'b00;
    chk(req, mode_invalid, exp_inv);
    chk(req, dll_rst_pulse, exp_dll);
    @(negedge clk);
    chk(req, dll_rst_pulse, 0);
  endtask

  task automatic burst(input int col, input int len, input bit ilv, input bit poke,
                       input string req);
    int s = col & (len - 1);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(col);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      int low = ilv ? (s ^ i) : ((s + i) % len);
      int exp = (col & ~(len - 1)) | low;
      if (i > 0) @(negedge clk);
      start = 1'b0;
      chk(req, busy, 1);
      chk(req, col_out, exp);
      chk(req, last, (i == len - 1) ? 1 : 0);
      if (poke && i == 0) begin start = 1'b1; start_col = COL_W'(col ^ 9'h155); end
    end
    @(negedge clk);
    start = 1'b0;
    chk(req, busy, 0);
  endtask

  task automatic refused(input string req);
    @(negedge clk);
    start = 1'b1; start_col = 10'h012;
    @(negedge clk);
    start = 1'b0;
    chk(req, busy, 0);
  endtask

  task automatic t_reset;
    chk("R1", busy, 0); chk("R1", last, 0);
    chk("R1", mode_invalid, 0); chk("R1", dll_rst_pulse, 0);
    burst(10'h001, 2, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_lengths;
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b010), "R2", 0, 0);
    burst(10'h2A6, 4, 1'b0, 1'b0, "R2");
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b011), "R2", 0, 0);
    burst(10'h0F5, 8, 1'b0, 1'b0, "R2");
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b000), "R2", 1, 0);
    refused("R10");
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b100), "R2", 1, 0);
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b111), "R2", 1, 0);
    refused("R10");
  endtask

  task automatic t_orders;
    load(2'b00, mw(2'b00, 3'b010, 1'b1, 3'b011), "R3", 0, 0);
    burst(10'h3FD, 8, 1'b1, 1'b0, "R3");
    load(2'b00, mw(2'b00, 3'b010, 1'b1, 3'b010), "R3", 0, 0);
    burst(10'h187, 4, 1'b1, 1'b0, "R3");
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b001), "R3", 0, 0);
    burst(10'h203, 2, 1'b0, 1'b0, "R3");
  endtask

  task automatic t_latency;
    load(2'b00, mw(2'b00, 3'b110, 1'b0, 3'b010), "R4", 0, 0);
    load(2'b00, mw(2'b00, 3'b011, 1'b0, 3'b010), "R4", 1, 0);
    refused("R10");
    load(2'b00, mw(2'b00, 3'b000, 1'b0, 3'b010), "R4", 1, 0);
  endtask

  task automatic t_opmode;
    load(2'b00, mw(2'b10, 3'b010, 1'b0, 3'b010), "R5", 0, 1);
    load(2'b00, mw(2'b01, 3'b010, 1'b0, 3'b010), "R5", 1, 0);
    load(2'b00, mw(2'b11, 3'b010, 1'b0, 3'b010), "R5", 1, 0);
    load(2'b00, mw(2'b00, 3'b010, 1'b0, 3'b011), "R5", 0, 0);
  endtask

  task automatic t_bank;
    load(2'b01, mw(2'b11, 3'b000, 1'b1, 3'b000), "R6", 0, 0);
    load(2'b10, mw(2'b10, 3'b010, 1'b1, 3'b001), "R6", 0, 0);
    burst(10'h11B, 8, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_busy_start;
    burst(10'h2C9, 8, 1'b0, 1'b1, "R9");
    load(2'b00, mw(2'b00, 3'b010, 1'b1, 3'b010), "R9", 0, 0);
    burst(10'h0D2, 4, 1'b1, 1'b1, "R9");
  endtask

  task automatic t_mid_load;
    @(negedge clk);
    start = 1'b1; start_col = 10'h3B6;
    @(negedge clk);
    start = 1'b0; mode_load = 1'b1; mode_word = mw(2'b00, 3'b010, 1'b0, 3'b011);
    chk("R8", col_out, 10'h3B6);
    @(negedge clk);
    mode_load = 1'b0;
    chk("R8", col_out, 10'h3B7); chk("R8", last, 0);
    @(negedge clk);
    chk("R8", col_out, 10'h3B4); chk("R8", last, 0);
    @(negedge clk);
    chk("R8", col_out, 10'h3B5); chk("R8", last, 1);
    @(negedge clk);
    chk("R8", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_orders();
    t_latency();
    t_opmode();
    t_bank();
    t_busy_start();
    t_mid_load();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule